// File: doc/BRIEF.md
# Guarded Serial DAC Programming Port

This block gives host software a small set of bus registers through which it drives a daisy-chained serial DAC string one bit at a time. Software raises a guard bit to open the port, lowers the chip-select bit to frame a transfer, and then writes one bit per bus cycle to a shift register. Each such write places the bit on the serial data line. After a programmable settle time, the block produces exactly one positive clock pulse on its own, so software never toggles the serial clock.

Writing the chip-select bit high ends the frame, and the DAC string latches what it holds. While the guard bit is low, chip-select is held inactive and the clock stays low, so a stray write cannot disturb the DACs. A status register shows the serial return from the far end of the chain, which lets software test the string. A separate control bit drives an ADC enable output.

While a clock pulse is in progress, the block raises `busy` and holds off every bus write. The host keeps its write asserted until `busy` drops, and the write is taken on that cycle.

Top module: `dac_prog_regif`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 0, `dac_sdi` is 0, `adc_en` is 0 and `busy` is 0. Address 0 reads 0x0000 and address 1 reads 0x0040.
- R2: While bit 5 of the register at address 0 (the guard bit) is 0, `dac_cs_n` stays 1 whatever bit 6 of address 1 holds, and `dac_sclk` stays 0.
- R3: While the guard bit is 1, `dac_cs_n` equals bit 6 of the register at address 1, taking the new value in the cycle after the write is accepted.
- R4: With the guard bit set, an accepted write to address 4 places `bus_wdata[0]` on `dac_sdi` in the next cycle. `dac_sclk` then stays low for SETTLE_CYC cycles, goes high for HIGH_CYC cycles and returns low, giving one pulse per write.
- R5: `busy` is 1 from the cycle after a pulse starts until `dac_sclk` has fallen. While `busy` is 1, a held write is not taken. It is taken at the first clock edge where `busy` is 0, so it waits SETTLE_CYC+HIGH_CYC cycles when it is issued right after a pulse starts.
- R6: While the guard bit is 0, a write to address 4 leaves `dac_sdi` unchanged, produces no clock pulse and does not raise `busy`.
- R7: Reading address 3 returns `dac_ret` in bit 4 and 0 in every other bit. A change on `dac_ret` appears after SYNC_STAGES clock edges and not earlier.
- R8: `adc_en` follows bit 7 of the register at address 0.
- R9: Addresses 0 and 1 read back all 16 written bits. Address 4 and unused addresses read 0. `bus_rdata` is 0 while `bus_rd` is 0. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, held by the host while `busy` is 1 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, combinational from the address |
| busy | output | 1 | A clock pulse is in progress and writes are held off |
| dac_cs_n | output | 1 | Active-low DAC chip-select |
| dac_sclk | output | 1 | Serial clock to the DAC string |
| dac_sdi | output | 1 | Serial data into the first DAC |
| dac_ret | input | 1 | Serial return from the last DAC |
| adc_en | output | 1 | ADC enable |

## Verification
A clock pulse and a chip-select change can meet when software writes the release of chip-select right after a data bit. If that write were taken at once, the DACs would latch before the last clock edge. The bench issues the address-1 write immediately after an address-4 write has been accepted, so it arrives while `busy` is high. The bench then counts the cycles the write is held off, expecting SETTLE_CYC+HIGH_CYC. It checks that chip-select rises only after the pulse has ended, and an assertion in the RTL requires chip-select to stay stable during every pulse.

// File: rtl/dac_prog_pkg.sv
package dac_prog_pkg;
  // Register addresses (software visible)
  localparam int ADR_CTRL_A = 0;
  localparam int ADR_CTRL_B = 1;
  localparam int ADR_STAT   = 3;
  localparam int ADR_SHIFT  = 4;
  // Bit positions
  localparam int BIT_GUARD  = 5;
  localparam int BIT_ADCEN  = 7;
  localparam int BIT_CSN    = 6;
  localparam int BIT_RET    = 4;

  typedef enum logic [1:0] {
    PG_IDLE   = 2'd0,
    PG_SETTLE = 2'd1,
    PG_HIGH   = 2'd2
  } pg_state_e;
endpackage

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic              we_b,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_a_q,
  output logic [DATA_W-1:0] ctrl_b_q
);
  import dac_prog_pkg::*;

  localparam logic [DATA_W-1:0] RST_B = DATA_W'(1) << BIT_CSN;

  logic [DATA_W-1:0] ctrl_a_d, ctrl_b_d;

  always_comb begin
    ctrl_a_d = ctrl_a_q;
    ctrl_b_d = ctrl_b_q;
    if (we_a) ctrl_a_d = wdata;
    if (we_b) ctrl_b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= RST_B;
    end else begin
      if (we_a) ctrl_a_q <= ctrl_a_d;
      if (we_b) ctrl_b_q <= ctrl_b_d;
    end
  end
endmodule

// File: rtl/dac_ret_sync.sv
module dac_ret_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dac_pulse_gen.sv
module dac_pulse_gen #(
  parameter int SETTLE_CYC = 2,
  parameter int HIGH_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_i,
  output logic sdi_o,
  output logic sclk_o,
  output logic busy_o
);
  import dac_prog_pkg::*;

  localparam int MAXC  = (SETTLE_CYC > HIGH_CYC) ? SETTLE_CYC : HIGH_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SET_LAST  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);

  pg_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sdi_q, sdi_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sdi_d = sdi_q;
    case (st_q)
      PG_IDLE: begin
        if (start_i) begin
          st_d  = PG_SETTLE;
          cnt_d = '0;
          sdi_d = bit_i;
        end
      end
      PG_SETTLE: begin
        if (cnt_q == SET_LAST) begin
          st_d  = PG_HIGH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PG_HIGH: begin
        if (cnt_q == HIGH_LAST) begin
          st_d  = PG_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = PG_IDLE;
        cnt_d = '0;
      end
    endcase
    sclk_d = (st_d == PG_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_IDLE;
      cnt_q  <= '0;
      sdi_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      if (start_i && st_q == PG_IDLE) sdi_q <= sdi_d;
    end
  end

  assign sdi_o  = sdi_q;
  assign sclk_o = sclk_q;
  assign busy_o = (st_q != PG_IDLE);

  // R5: a new pulse is only requested while idle
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> st_q == PG_IDLE);
  // R4: data line stays put throughout a pulse
  assert_sdi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PG_IDLE && $past(st_q) != PG_IDLE) |-> $stable(sdi_q));
  // R4: clock rises only after the settle phase
  assert_rise_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(st_q) == PG_SETTLE);
  // R5: falling clock ends the pulse
  assert_fall_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> st_q == PG_IDLE);
endmodule

// File: rtl/dac_prog_regif.sv
module dac_prog_regif #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 2,
  parameter int HIGH_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  input  logic              dac_ret,
  output logic              adc_en
);
  import dac_prog_pkg::*;

  logic              wr_ok, sel_a, sel_b, sel_st, sel_sh;
  logic              guard, start, ret_s;
  logic [DATA_W-1:0] ctrl_a, ctrl_b, stat_w;

  assign sel_a  = (int'(bus_addr) == ADR_CTRL_A);
  assign sel_b  = (int'(bus_addr) == ADR_CTRL_B);
  assign sel_st = (int'(bus_addr) == ADR_STAT);
  assign sel_sh = (int'(bus_addr) == ADR_SHIFT);

  assign wr_ok = bus_wr && !busy;
  assign guard = ctrl_a[BIT_GUARD];
  assign start = wr_ok && sel_sh && guard;

  dac_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_a     (wr_ok && sel_a),
    .we_b     (wr_ok && sel_b),
    .wdata    (bus_wdata),
    .ctrl_a_q (ctrl_a),
    .ctrl_b_q (ctrl_b)
  );

  dac_pulse_gen #(.SETTLE_CYC(SETTLE_CYC), .HIGH_CYC(HIGH_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .bit_i   (bus_wdata[0]),
    .sdi_o   (dac_sdi),
    .sclk_o  (dac_sclk),
    .busy_o  (busy)
  );

  dac_ret_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dac_ret),
    .q_o   (ret_s)
  );

  assign dac_cs_n = guard ? ctrl_b[BIT_CSN] : 1'b1;
  assign adc_en   = ctrl_a[BIT_ADCEN];

  always_comb begin
    stat_w          = '0;
    stat_w[BIT_RET] = ret_s;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_a)       bus_rdata = ctrl_a;
      else if (sel_b)  bus_rdata = ctrl_b;
      else if (sel_st) bus_rdata = stat_w;
    end
  end

  // R2: clock never pulses while the guard bit is clear
  assert_sclk_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !guard |-> !dac_sclk);
  // R5: chip-select cannot move inside a pulse
  assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dac_cs_n));
  // R6: a guarded-off shift write starts nothing
  assert_no_start_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_sh && !guard && !busy) |=> !busy);
endmodule

// File: tb/dac_prog_regif_tb.sv
`timescale 1ns/1ps
module dac_prog_regif_tb_top;
  localparam int S = 2;
  localparam int H = 2;
  localparam int Y = 2;

  logic        clk, rst_n;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, busy, dac_cs_n, dac_sclk, dac_sdi, dac_ret, adc_en;
  int          checks, errors;

  dac_prog_regif #(.SETTLE_CYC(S), .HIGH_CYC(H), .SYNC_STAGES(Y)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .busy(busy),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
    .dac_ret(dac_ret), .adc_en(adc_en));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns after the next negedge with wr low
  task automatic do_write(input logic [2:0] a, input logic [15:0] d, output int stalls);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; stalls = 0;
    while (busy) begin @(negedge clk); stalls++; end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1 cs_n", 16'(dac_cs_n), 16'h1);
    chk("R1 sclk", 16'(dac_sclk), 16'h0);
    chk("R1 sdi", 16'(dac_sdi), 16'h0);
    chk("R1 adc_en", 16'(adc_en), 16'h0);
    chk("R1 busy", 16'(busy), 16'h0);
    do_read(3'd0, r); chk("R1 reg0", r, 16'h0000);
    do_read(3'd1, r); chk("R1 reg1", r, 16'h0040);
  endtask

  task automatic t_guard();
    int st;
    logic seen_clk, seen_busy;
    do_write(3'd1, 16'h0000, st);
    chk("R2 cs_n held high", 16'(dac_cs_n), 16'h1);
    do_write(3'd4, 16'h0001, st);
    seen_clk = 1'b0; seen_busy = 1'b0;
    for (int i = 0; i < 8; i++) begin
      seen_clk  |= dac_sclk;
      seen_busy |= busy;
      @(negedge clk);
    end
    chk("R2 sclk stays low", 16'(seen_clk), 16'h0);
    chk("R6 busy stays low", 16'(seen_busy), 16'h0);
    chk("R6 sdi unchanged", 16'(dac_sdi), 16'h0);
  endtask

  task automatic t_cs();
    int st;
    do_write(3'd0, 16'h0020, st);
    chk("R3 cs_n low when guard set", 16'(dac_cs_n), 16'h0);
    do_write(3'd1, 16'h0040, st);
    chk("R3 cs_n released", 16'(dac_cs_n), 16'h1);
    do_write(3'd1, 16'h0000, st);
    chk("R3 cs_n asserted", 16'(dac_cs_n), 16'h0);
  endtask

  task automatic t_pulse(input logic b);
    int st, bad_clk, bad_busy;
    do_write(3'd4, {15'h0, b}, st);
    chk("R4 sdi follows bit0", 16'(dac_sdi), 16'(b));
    bad_clk = 0; bad_busy = 0;
    for (int n = 1; n <= S + H + 2; n++) begin
      if (dac_sclk !== ((n > S) && (n <= S + H))) bad_clk++;
      if (busy !== (n <= S + H)) bad_busy++;
      @(negedge clk);
    end
    chk("R4 sclk pulse shape", 16'(bad_clk), 16'h0);
    chk("R5 busy window", 16'(bad_busy), 16'h0);
  endtask

  task automatic t_stall();
    int st;
    do_write(3'd4, 16'h0001, st);
    do_write(3'd1, 16'h0040, st);
    chk("R5 stall cycles", 16'(st), 16'(S + H));
    chk("R5 cs_n released after pulse", 16'(dac_cs_n), 16'h1);
    do_write(3'd1, 16'h0000, st);
    chk("R5 no stall when idle", 16'(st), 16'h0);
  endtask

  task automatic t_adc();
    int st;
    logic [15:0] r;
    do_write(3'd0, 16'h00A0, st);
    chk("R8 adc_en on", 16'(adc_en), 16'h1);
    do_read(3'd0, r); chk("R9 reg0 readback", r, 16'h00A0);
    do_write(3'd0, 16'h0020, st);
    chk("R8 adc_en off", 16'(adc_en), 16'h0);
  endtask

  task automatic t_status();
    logic [15:0] r;
    dac_ret = 1'b1;
    @(negedge clk);
    do_read(3'd3, r); chk("R7 not yet visible", r, 16'h0000);
    @(negedge clk);
    do_read(3'd3, r); chk("R7 ret high", r, 16'h0010);
    dac_ret = 1'b0;
    repeat (Y) @(negedge clk);
    do_read(3'd3, r); chk("R7 ret low", r, 16'h0000);
  endtask

  task automatic t_map();
    int st;
    logic [15:0] r;
    do_write(3'd1, 16'hBEAF, st);
    do_read(3'd1, r); chk("R9 reg1 readback", r, 16'hBEAF);
    do_write(3'd3, 16'hFFFF, st);
    do_read(3'd3, r); chk("R9 status not writable", r, 16'h0000);
    repeat (S + H + 2) @(negedge clk);
    do_read(3'd4, r); chk("R9 addr4 reads zero", r, 16'h0000);
    do_read(3'd5, r); chk("R9 unused reads zero", r, 16'h0000);
    bus_addr = 3'd1; bus_rd = 1'b0;
    #1 chk("R9 rdata zero without rd", bus_rdata, 16'h0000);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0; dac_ret = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_guard();
    t_cs();
    t_pulse(1'b1);
    t_pulse(1'b0);
    t_stall();
    t_adc();
    t_status();
    t_map();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule